// File: doc/BRIEF.md
# Checksummed Serial Frame Receiver

This block takes a single asynchronous serial input line and rebuilds link frames from it. Each character on the line carries eleven bits. Three frame shapes are recognised, and the first character of a frame picks the shape. A short frame holds a control byte guarded by a check byte. A long frame holds a length field that appears twice, a control byte, a run of user bytes and a check byte. A lone acknowledge character is a complete frame in its own right.

The block checks every character and every frame. A frame that passes is announced with a one-cycle pulse, together with its kind, its control byte and its user-data count. Its user bytes then follow on a byte stream. A frame that fails is dropped without any partial output, and a single error pulse is raised. After any error the receiver goes deaf until the line has been quiet for a set number of bit times. Any character seen in that deaf window is thrown away and restarts the quiet timer.

Top module: `frx_frame_rx`

## Requirements
- R1: A character is a 0 start bit, 8 data bits sent LSB first, an even parity bit over the data and a 1 stop bit. The line rests at 1. A wrong parity bit, a 0 stop bit, or a start bit that reads 1 at its middle raises `err_pulse` and drops the frame that is open.
- R2: `rate_sel` selects the bit time as 16·BASE_DIV·2^`rate_sel` clock cycles: 0 = 19200, 1 = 9600, 2 = 4800, 3 = 2400, 4 = 1200 baud. The values 5 to 7 behave like 0.
- R3: A short frame is 0x10, C, S, 0x16 with S equal to C. It gives one `frm_ok` pulse with `frm_kind` = 1, `frm_ctrl` = C and `frm_ulen` = 0. The kind codes are 1 for short, 2 for long and 3 for acknowledge.
- R4: A long frame is 0x68, L, L, 0x68, C, D1..D(L-1), S, 0x16, so it has L+6 characters. It gives `frm_ok` with `frm_kind` = 2, `frm_ctrl` = C and `frm_ulen` = L-1. Starting the cycle after `frm_ok`, D1..D(L-1) appear in order on `pay_byte`, one per cycle with `pay_valid` high, and `pay_last` marks the final byte.
- R5: S must equal the sum modulo 256 of C and all user bytes. Any other value raises `err_pulse` and gives no `frm_ok`.
- R6: The second length copy must equal the first, L must lie in 2..23, and the fourth character must be 0x68. Any breach raises `err_pulse` and gives no `frm_ok`.
- R7: The closing character of a short or long frame must be 0x16. Any other value raises `err_pulse` and gives no `frm_ok`.
- R8: The single character 0xE5, received while no frame is open, gives `frm_ok` with `frm_kind` = 3 and `frm_ulen` = 0.
- R9: Any character other than 0x10, 0x68 or 0xE5, received while no frame is open, raises `err_pulse`.
- R10: If the line stays idle for IDLE_BITS (33) bit times while a frame is open, `err_pulse` is raised and the frame is dropped.
- R11: After an error, no frame is accepted until the line has been idle for IDLE_BITS bit times. Characters that arrive in that window are discarded without an error pulse, and each one restarts the idle count.
- R12: While `rst_n` is low, `frm_ok`, `pay_valid`, `pay_last` and `err_pulse` are 0.
- R13: `frm_ok` and `err_pulse` each last one cycle and never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line | input | 1 | Serial input line, asynchronous to clk |
| rate_sel | input | 3 | Baud rate select |
| frm_ok | output | 1 | One-cycle pulse when a frame is accepted |
| frm_kind | output | 2 | Kind of the accepted frame (1 short, 2 long, 3 acknowledge) |
| frm_ctrl | output | 8 | Control byte of the accepted frame |
| frm_ulen | output | $clog2(MAX_LEN) | Number of user bytes that follow |
| pay_valid | output | 1 | User byte valid on pay_byte |
| pay_byte | output | 8 | User data byte |
| pay_last | output | 1 | Marks the final user byte |
| err_pulse | output | 1 | One-cycle pulse on a detected error |

## Verification
The properties assume that `rate_sel` stays constant for the whole of a frame. They also assume that a character lasts far longer than the 22-cycle payload burst, so a new frame's user bytes cannot overlap the previous burst. The stimulus meets both conditions. It changes the rate only while the line has been idle for many bit times. It runs with a small BASE_DIV, which still gives 352 clocks per character. Every character is driven at whole bit-time steps, on the falling clock edge. Random control bytes, payloads and lengths are mixed with directed length extremes and with deliberately corrupted characters and frames.

// File: rtl/frx_pkg.sv
package frx_pkg;
    // Frame kinds reported on frm_kind
    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_SHORT = 2'd1,
        KIND_LONG  = 2'd2,
        KIND_ACK   = 2'd3
    } frm_kind_t;

    // Framing characters
    localparam logic [7:0] CH_SHORT_HDR = 8'h10;
    localparam logic [7:0] CH_LONG_HDR  = 8'h68;
    localparam logic [7:0] CH_TAIL      = 8'h16;
    localparam logic [7:0] CH_ACK       = 8'hE5;

    // Oversampling factor per bit
    localparam int OVS = 16;
endpackage

// File: rtl/frx_char_rx.sv
// Character receiver: two-flop synchroniser, 16x tick generator and
// mid-bit sampler for start/8 data/even parity/stop characters.
// Assumes rate_sel is stable while a character is in flight.
module frx_char_rx #(
    parameter int BASE_DIV = 52
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic [2:0] rate_sel,
    output logic       tick,
    output logic       busy,
    output logic       ch_valid,
    output logic [7:0] ch_data,
    output logic       ch_err
);
    import frx_pkg::*;

    localparam int DIV_W = $clog2(BASE_DIV) + 6;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;

    logic             rx_meta, rx_s;
    logic [DIV_W-1:0] div_cnt, div_lim;
    logic [2:0]       shamt;
    rx_st_t           st;
    logic [3:0]       sub;
    logic [3:0]       bidx;
    logic [9:0]       shreg;

    // Pick divisor from rate select; out-of-range codes fall back to the fastest rate
    always_comb begin
        shamt   = (rate_sel > 3'd4) ? 3'd0 : rate_sel;
        div_lim = (DIV_W'(BASE_DIV) << shamt) - 1'b1;
    end

    // Bring the asynchronous line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            rx_meta <= rx_line;
            rx_s    <= rx_meta;
        end
    end

    // Generate one tick per oversample period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (div_cnt >= div_lim) begin
            div_cnt <= '0;
            tick    <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            tick    <= 1'b0;
        end
    end

    // Sample start, data, parity and stop at their bit centres
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= RX_IDLE;
            sub      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            ch_valid <= 1'b0;
            ch_err   <= 1'b0;
            ch_data  <= '0;
        end else begin
            ch_valid <= 1'b0;
            ch_err   <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (tick && !rx_s) begin
                        st  <= RX_START;
                        sub <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (sub == 4'(OVS/2 - 1)) begin
                            sub  <= '0;
                            bidx <= '0;
                            if (rx_s) begin
                                st     <= RX_IDLE;
                                ch_err <= 1'b1;
                            end else begin
                                st <= RX_BITS;
                            end
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                end
                RX_BITS: begin
                    if (tick) begin
                        if (sub == 4'(OVS - 1)) begin
                            sub   <= '0;
                            shreg <= {rx_s, shreg[9:1]};
                            if (bidx == 4'd9) begin
                                st      <= RX_IDLE;
                                ch_data <= shreg[8:1];
                                if (rx_s && !(^shreg[9:1]))
                                    ch_valid <= 1'b1;
                                else
                                    ch_err <= 1'b1;
                            end else begin
                                bidx <= bidx + 1'b1;
                            end
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    assign busy = (st != RX_IDLE);
endmodule

// File: rtl/frx_idle_mon.sv
// Idle-line monitor: counts quiet bit times while no character is in
// flight and holds the post-error blackout flag until the count is met.
// Assumes busy rises within one tick of a start edge.
module frx_idle_mon #(
    parameter int IDLE_BITS = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic busy,
    input  logic err_set,
    output logic gap,
    output logic blk
);
    import frx_pkg::*;

    localparam int LIM = IDLE_BITS * OVS;
    localparam int CW  = $clog2(LIM + 1);

    logic [CW-1:0] qcnt;

    // Count quiet ticks, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)
            qcnt <= '0;
        else if (busy)
            qcnt <= '0;
        else if (tick && qcnt != CW'(LIM))
            qcnt <= qcnt + 1'b1;
    end

    assign gap = (qcnt == CW'(LIM));

    // Blackout set by an error, released by a long enough quiet spell
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk <= 1'b0;
        else if (err_set)
            blk <= 1'b1;
        else if (gap)
            blk <= 1'b0;
    end
endmodule

// File: rtl/frx_parser.sv
// Frame parser: walks the short, long and acknowledge formats, checks
// lengths, sums and closing characters, buffers user bytes and streams
// them out after the frame is accepted.
// Assumes characters are spaced far wider than a payload burst.
module frx_parser #(
    parameter int MIN_LEN = 2,
    parameter int MAX_LEN = 23
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ch_valid,
    input  logic [7:0]                 ch_data,
    input  logic                       ch_err,
    input  logic                       gap,
    input  logic                       blk,
    output logic                       frm_ok,
    output logic [1:0]                 frm_kind,
    output logic [7:0]                 frm_ctrl,
    output logic [$clog2(MAX_LEN)-1:0] frm_ulen,
    output logic                       pay_valid,
    output logic [7:0]                 pay_byte,
    output logic                       pay_last,
    output logic                       err_set
);
    import frx_pkg::*;

    localparam int UMAX = MAX_LEN - 1;
    localparam int UW   = $clog2(MAX_LEN);
    localparam int LW   = $clog2(MAX_LEN + 1);

    typedef enum logic [3:0] {
        P_IDLE, P_S_CTRL, P_S_SUM, P_S_TAIL,
        P_L_LEN1, P_L_LEN2, P_L_HDR2, P_L_CTRL,
        P_L_DATA, P_L_SUM, P_L_TAIL
    } p_st_t;

    p_st_t         st;
    logic [7:0]    ctrl_r;
    logic [7:0]    sum_r;
    logic [LW-1:0] len_r;
    logic [LW-1:0] rem_r;
    logic [UW-1:0] widx;
    logic [UW-1:0] ridx;
    logic [UW-1:0] rlen;
    logic          strm;
    logic          take;
    logic          wr_en;
    logic [7:0]    ubuf [UMAX];

    assign take  = ch_valid && !blk;
    assign wr_en = take && (st == P_L_DATA);

    // Store user bytes of a long frame
    always_ff @(posedge clk) begin
        if (wr_en)
            ubuf[widx] <= ch_data;
    end

    // Frame state machine and acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= P_IDLE;
            ctrl_r   <= '0;
            sum_r    <= '0;
            len_r    <= '0;
            rem_r    <= '0;
            widx     <= '0;
            frm_ok   <= 1'b0;
            frm_kind <= KIND_NONE;
            frm_ctrl <= '0;
            frm_ulen <= '0;
            err_set  <= 1'b0;
        end else begin
            frm_ok  <= 1'b0;
            err_set <= 1'b0;
            if (ch_err && !blk) begin
                err_set <= 1'b1;
                st      <= P_IDLE;
            end else if (take) begin
                case (st)
                    P_IDLE: begin
                        if (ch_data == CH_SHORT_HDR)
                            st <= P_S_CTRL;
                        else if (ch_data == CH_LONG_HDR)
                            st <= P_L_LEN1;
                        else if (ch_data == CH_ACK) begin
                            frm_ok   <= 1'b1;
                            frm_kind <= KIND_ACK;
                            frm_ctrl <= '0;
                            frm_ulen <= '0;
                        end else
                            err_set <= 1'b1;
                    end
                    P_S_CTRL: begin
                        ctrl_r <= ch_data;
                        st     <= P_S_SUM;
                    end
                    P_S_SUM: begin
                        if (ch_data == ctrl_r)
                            st <= P_S_TAIL;
                        else begin
                            err_set <= 1'b1;
                            st      <= P_IDLE;
                        end
                    end
                    P_S_TAIL: begin
                        st <= P_IDLE;
                        if (ch_data == CH_TAIL) begin
                            frm_ok   <= 1'b1;
                            frm_kind <= KIND_SHORT;
                            frm_ctrl <= ctrl_r;
                            frm_ulen <= '0;
                        end else
                            err_set <= 1'b1;
                    end
                    P_L_LEN1: begin
                        if (ch_data >= 8'(MIN_LEN) && ch_data <= 8'(MAX_LEN)) begin
                            len_r <= ch_data[LW-1:0];
                            st    <= P_L_LEN2;
                        end else begin
                            err_set <= 1'b1;
                            st      <= P_IDLE;
                        end
                    end
                    P_L_LEN2: begin
                        if (ch_data == 8'(len_r))
                            st <= P_L_HDR2;
                        else begin
                            err_set <= 1'b1;
                            st      <= P_IDLE;
                        end
                    end
                    P_L_HDR2: begin
                        if (ch_data == CH_LONG_HDR)
                            st <= P_L_CTRL;
                        else begin
                            err_set <= 1'b1;
                            st      <= P_IDLE;
                        end
                    end
                    P_L_CTRL: begin
                        ctrl_r <= ch_data;
                        sum_r  <= ch_data;
                        rem_r  <= len_r - 1'b1;
                        widx   <= '0;
                        st     <= P_L_DATA;
                    end
                    P_L_DATA: begin
                        sum_r <= sum_r + ch_data;
                        widx  <= widx + 1'b1;
                        rem_r <= rem_r - 1'b1;
                        if (rem_r == LW'(1))
                            st <= P_L_SUM;
                    end
                    P_L_SUM: begin
                        if (ch_data == sum_r)
                            st <= P_L_TAIL;
                        else begin
                            err_set <= 1'b1;
                            st      <= P_IDLE;
                        end
                    end
                    P_L_TAIL: begin
                        st <= P_IDLE;
                        if (ch_data == CH_TAIL) begin
                            frm_ok   <= 1'b1;
                            frm_kind <= KIND_LONG;
                            frm_ctrl <= ctrl_r;
                            frm_ulen <= widx;
                        end else
                            err_set <= 1'b1;
                    end
                    default: st <= P_IDLE;
                endcase
            end else if (gap && st != P_IDLE) begin
                err_set <= 1'b1;
                st      <= P_IDLE;
            end
        end
    end

    // Stream buffered user bytes after a long frame is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strm      <= 1'b0;
            ridx      <= '0;
            rlen      <= '0;
            pay_valid <= 1'b0;
            pay_last  <= 1'b0;
            pay_byte  <= '0;
        end else begin
            pay_valid <= 1'b0;
            pay_last  <= 1'b0;
            if (take && st == P_L_TAIL && ch_data == CH_TAIL) begin
                strm <= 1'b1;
                ridx <= '0;
                rlen <= widx;
            end else if (strm) begin
                pay_valid <= 1'b1;
                pay_byte  <= ubuf[ridx];
                ridx      <= ridx + 1'b1;
                if (ridx == rlen - 1'b1) begin
                    pay_last <= 1'b1;
                    strm     <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/frx_frame_rx.sv
// Top level of the checksummed frame receiver: character receiver,
// idle-line monitor and frame parser.
// Assumes rx_line idles high and rate_sel changes only between frames.
module frx_frame_rx #(
    parameter int BASE_DIV  = 52,
    parameter int IDLE_BITS = 33,
    parameter int MIN_LEN   = 2,
    parameter int MAX_LEN   = 23
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_line,
    input  logic [2:0]                 rate_sel,
    output logic                       frm_ok,
    output logic [1:0]                 frm_kind,
    output logic [7:0]                 frm_ctrl,
    output logic [$clog2(MAX_LEN)-1:0] frm_ulen,
    output logic                       pay_valid,
    output logic [7:0]                 pay_byte,
    output logic                       pay_last,
    output logic                       err_pulse
);
    logic       tick, busy, ch_valid, ch_err, gap, blk, err_set;
    logic [7:0] ch_data;

    frx_char_rx #(.BASE_DIV(BASE_DIV)) u_char (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_line  (rx_line),
        .rate_sel (rate_sel),
        .tick     (tick),
        .busy     (busy),
        .ch_valid (ch_valid),
        .ch_data  (ch_data),
        .ch_err   (ch_err)
    );

    frx_idle_mon #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .busy    (busy),
        .err_set (err_set),
        .gap     (gap),
        .blk     (blk)
    );

    frx_parser #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_valid  (ch_valid),
        .ch_data   (ch_data),
        .ch_err    (ch_err),
        .gap       (gap),
        .blk       (blk),
        .frm_ok    (frm_ok),
        .frm_kind  (frm_kind),
        .frm_ctrl  (frm_ctrl),
        .frm_ulen  (frm_ulen),
        .pay_valid (pay_valid),
        .pay_byte  (pay_byte),
        .pay_last  (pay_last),
        .err_set   (err_set)
    );

    assign err_pulse = err_set;
endmodule

// File: rtl/frx_frame_rx_chk.sv
// Port-level properties of the frame receiver, bound to the top module.
// Assumes rate_sel is stable during frames and characters are long
// compared to a payload burst.
module frx_frame_rx_chk #(
    parameter int MAX_LEN = 23
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       frm_ok,
    input logic [1:0]                 frm_kind,
    input logic [$clog2(MAX_LEN)-1:0] frm_ulen,
    input logic                       pay_valid,
    input logic                       pay_last,
    input logic                       err_pulse
);
    localparam int UW = $clog2(MAX_LEN);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !frm_ok && !pay_valid && !err_pulse); // R12
    AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(frm_ok && err_pulse)); // R13
    AST_OK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frm_ok |=> !frm_ok); // R13
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) err_pulse |=> !err_pulse); // R13
    AST_KIND_SET: assert property (@(posedge clk) disable iff (!rst_n) frm_ok |-> frm_kind != 2'd0); // R3
    AST_SHORT_NOLEN: assert property (@(posedge clk) disable iff (!rst_n) frm_ok && frm_kind != 2'd2 |-> frm_ulen == '0); // R8
    AST_LONG_LEN: assert property (@(posedge clk) disable iff (!rst_n) frm_ok && frm_kind == 2'd2 |-> frm_ulen >= UW'(1) && frm_ulen <= UW'(MAX_LEN - 1)); // R4
    AST_PAY_START: assert property (@(posedge clk) disable iff (!rst_n) pay_valid && !$past(pay_valid) |-> $past(frm_ok) && $past(frm_kind) == 2'd2); // R4
    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n) pay_last |-> pay_valid); // R4
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n) pay_last |=> !pay_valid); // R4
endmodule

bind frx_frame_rx frx_frame_rx_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_ok    (frm_ok),
    .frm_kind  (frm_kind),
    .frm_ulen  (frm_ulen),
    .pay_valid (pay_valid),
    .pay_last  (pay_last),
    .err_pulse (err_pulse)
);

// File: tb/frx_frame_rx_test.sv
module frx_frame_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int BASE_DIV   = 2;
    localparam int MAX_LEN    = 23;
    localparam int UW         = $clog2(MAX_LEN);
    localparam int WATCHDOG   = 195000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_line = 1'b1;
    logic [2:0]    rate_sel = 3'd0;
    logic          frm_ok, pay_valid, pay_last, err_pulse;
    logic [1:0]    frm_kind;
    logic [7:0]    frm_ctrl, pay_byte;
    logic [UW-1:0] frm_ulen;

    frx_frame_rx #(.BASE_DIV(BASE_DIV), .MAX_LEN(MAX_LEN)) uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rate_sel(rate_sel),
        .frm_ok(frm_ok), .frm_kind(frm_kind), .frm_ctrl(frm_ctrl), .frm_ulen(frm_ulen),
        .pay_valid(pay_valid), .pay_byte(pay_byte), .pay_last(pay_last), .err_pulse(err_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Monitor state
    int         m_ok = 0, m_err = 0, m_npay = 0, m_lastidx = -1;
    int         m_kind = 0, m_ctrl = 0, m_ulen = 0;
    logic [7:0] m_pay [0:31];

    // Frame under construction
    logic [7:0] fr [0:31];
    int         fr_n = 0;
    logic [7:0] exp_dat [0:31];

    always @(negedge clk) begin
        if (rst_n) begin
            if (frm_ok) begin
                m_ok++;
                m_kind = frm_kind;
                m_ctrl = frm_ctrl;
                m_ulen = frm_ulen;
            end
            if (pay_valid) begin
                if (m_npay < 32) m_pay[m_npay] = pay_byte;
                if (pay_last) m_lastidx = m_npay;
                m_npay++;
            end
            if (err_pulse) m_err++;
        end
    end

    task automatic clear_mon();
        m_ok = 0; m_err = 0; m_npay = 0; m_lastidx = -1;
        m_kind = 0; m_ctrl = 0; m_ulen = 0;
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bit_clks();
        int e = (rate_sel > 3'd4) ? 0 : int'(rate_sel);
        return 16 * BASE_DIV * (1 << e);
    endfunction

    task automatic bit_wait();
        repeat (bit_clks()) @(negedge clk);
    endtask

    task automatic idle_bits(int n);
        rx_line = 1'b1;
        repeat (n) bit_wait();
    endtask

    task automatic send_char(logic [7:0] d, bit bad_par, bit bad_stop);
        rx_line = 1'b0; bit_wait();
        for (int i = 0; i < 8; i++) begin rx_line = d[i]; bit_wait(); end
        rx_line = (^d) ^ bad_par; bit_wait();
        rx_line = ~bad_stop; bit_wait();
        rx_line = 1'b1;
    endtask

    task automatic send_frame();
        for (int i = 0; i < fr_n; i++) send_char(fr[i], 1'b0, 1'b0);
    endtask

    function automatic logic [7:0] exp_sum(logic [7:0] ctrl, int nu);
        logic [7:0] s = ctrl;
        for (int i = 0; i < nu; i++) s = s + exp_dat[i];
        return s;
    endfunction

    task automatic build_short(logic [7:0] c);
        fr[0] = 8'h10; fr[1] = c; fr[2] = c; fr[3] = 8'h16; fr_n = 4;
    endtask

    task automatic build_long(int len, logic [7:0] c);
        for (int i = 0; i < len - 1; i++) exp_dat[i] = 8'($urandom);
        fr[0] = 8'h68; fr[1] = 8'(len); fr[2] = 8'(len); fr[3] = 8'h68; fr[4] = c;
        for (int i = 0; i < len - 1; i++) fr[5 + i] = exp_dat[i];
        fr[4 + len] = exp_sum(c, len - 1);
        fr[5 + len] = 8'h16;
        fr_n = len + 6;
    endtask

    task automatic expect_long(string req, int len, logic [7:0] c);
        check({req, " ok count"}, m_ok, 1);
        check({req, " kind"}, m_kind, 2);
        check({req, " ctrl"}, m_ctrl, int'(c));
        check({req, " ulen"}, m_ulen, len - 1);
        check({req, " payload count"}, m_npay, len - 1);
        check({req, " last index"}, m_lastidx, len - 2);
        for (int i = 0; i < len - 1; i++) check({req, " payload byte"}, int'(m_pay[i]), int'(exp_dat[i]));
        check({req, " no error"}, m_err, 0);
    endtask

    task automatic expect_reject(string req);
        check({req, " error count"}, m_err, 1);
        check({req, " no frame"}, m_ok, 0);
    endtask

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", WATCHDOG, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] c;
        int len;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        // R12 reset state
        check("R12 frm_ok in reset", frm_ok, 0);
        check("R12 pay_valid in reset", pay_valid, 0);
        check("R12 err_pulse in reset", err_pulse, 0);
        rst_n = 1'b1;
        idle_bits(4);
        clear_mon();

        // R3 short frames
        for (int k = 0; k < 3; k++) begin
            c = 8'($urandom);
            build_short(c); send_frame(); idle_bits(2);
            check("R3 ok count", m_ok, 1);
            check("R3 kind", m_kind, 1);
            check("R3 ctrl", m_ctrl, int'(c));
            check("R3 ulen", m_ulen, 0);
            check("R3 no error", m_err, 0);
            clear_mon();
        end

        // R8 acknowledge
        send_char(8'hE5, 1'b0, 1'b0); idle_bits(2);
        check("R8 ok count", m_ok, 1);
        check("R8 kind", m_kind, 3);
        check("R8 ulen", m_ulen, 0);
        clear_mon();

        // R4 / R1 long frames: extremes then random lengths
        build_long(2, 8'h53); send_frame(); idle_bits(2);
        expect_long("R4 min length", 2, 8'h53); clear_mon();
        build_long(23, 8'hA7); send_frame(); idle_bits(2);
        expect_long("R4 max length", 23, 8'hA7); clear_mon();
        for (int k = 0; k < 4; k++) begin
            len = 2 + int'($urandom % 22);
            c = 8'($urandom);
            build_long(len, c); send_frame(); idle_bits(2);
            expect_long("R4 R1 random", len, c); clear_mon();
        end

        // R2 slower rate and out-of-range code
        idle_bits(2); rate_sel = 3'd1; idle_bits(2);
        build_long(4, 8'h3C); send_frame(); idle_bits(2);
        expect_long("R2 9600", 4, 8'h3C); clear_mon();
        rate_sel = 3'd7; idle_bits(2);
        build_short(8'h7B); send_frame(); idle_bits(2);
        check("R2 code 7 ok", m_ok, 1);
        check("R2 code 7 ctrl", m_ctrl, 8'h7B);
        clear_mon();
        rate_sel = 3'd0; idle_bits(2);

        // R5 bad checksum
        build_long(6, 8'h11); fr[10] = fr[10] + 8'd1; send_frame(); idle_bits(40);
        expect_reject("R5 bad sum"); clear_mon();

        // R6 length faults
        build_long(5, 8'h22); fr[2] = 8'd6; send_frame(); idle_bits(40);
        expect_reject("R6 length copy mismatch"); clear_mon();
        build_long(5, 8'h22); fr[1] = 8'd1; fr[2] = 8'd1; send_frame(); idle_bits(40);
        expect_reject("R6 length too small"); clear_mon();
        fr[0] = 8'h68; fr[1] = 8'd24; fr[2] = 8'd24; fr[3] = 8'h68; fr_n = 4; send_frame(); idle_bits(40);
        expect_reject("R6 length too large"); clear_mon();
        build_long(5, 8'h22); fr[3] = 8'h67; send_frame(); idle_bits(40);
        expect_reject("R6 second header"); clear_mon();

        // R7 bad closing characters
        build_long(3, 8'h44); fr[8] = 8'h17; send_frame(); idle_bits(40);
        expect_reject("R7 long tail"); clear_mon();
        build_short(8'h44); fr[3] = 8'h15; send_frame(); idle_bits(40);
        expect_reject("R7 short tail"); clear_mon();
        build_short(8'h44); fr[2] = 8'h45; send_frame(); idle_bits(40);
        expect_reject("R3 short check byte"); clear_mon();

        // R9 stray character
        send_char(8'h55, 1'b0, 1'b0); idle_bits(40);
        expect_reject("R9 stray char"); clear_mon();

        // R1 parity and stop errors inside a frame
        build_short(8'h21);
        send_char(fr[0], 1'b0, 1'b0); send_char(fr[1], 1'b1, 1'b0);
        send_char(fr[2], 1'b0, 1'b0); send_char(fr[3], 1'b0, 1'b0); idle_bits(40);
        expect_reject("R1 parity"); clear_mon();
        send_char(8'h10, 1'b0, 1'b0); send_char(8'h21, 1'b0, 1'b1); idle_bits(40);
        expect_reject("R1 stop bit"); clear_mon();

        // R10 idle gap inside a frame, then recovery
        send_char(8'h68, 1'b0, 1'b0); send_char(8'h05, 1'b0, 1'b0); idle_bits(40);
        expect_reject("R10 mid-frame gap"); clear_mon();
        build_short(8'h66); send_frame(); idle_bits(2);
        check("R10 recovery ok", m_ok, 1);
        clear_mon();

        // R11 blackout: tail char restarts timer, frame 20 bits later dropped
        build_short(8'h30); fr[2] = 8'h31; send_frame(); idle_bits(20);
        build_short(8'h30); send_frame(); idle_bits(2);
        check("R11 blackout error count", m_err, 1);
        check("R11 blackout frame dropped", m_ok, 0);
        idle_bits(40); clear_mon();
        build_short(8'h30); send_frame(); idle_bits(2);
        check("R11 after blackout ok", m_ok, 1);
        check("R11 after blackout ctrl", m_ctrl, 8'h30);
        check("R11 after blackout no error", m_err, 0);
        clear_mon();

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule